// File: doc/BRIEF.md
# Two-Slot Delayed Symbol Channel

This block models one direction of a link between two nodes. A sender puts line symbols (REQ, ACK or IDLE) onto the channel with a send strobe, and each symbol comes out at the far end a fixed number of clock ticks later as a one-cycle receive strobe carrying the same code. The channel can hold two distinct symbols at once, an older and a newer. Each has its own age. A symbol leaves the channel when its age reaches the programmed delay.

Sending the symbol that is already newest on the channel changes nothing, because the line already carries it. Sending a different symbol while one is in flight forms an ordered pair. The newer symbol starts a fresh age and the older one keeps ageing. A third distinct symbol cannot fit, so it is dropped and an overflow pulse is raised. A ten-value state output reports which symbols are in flight and in what order. A neighbouring model can decode it.

Top module: `sym_link_delay`

## Requirements
- R1: After reset the channel is empty: `link_state` is 0, and `rx_valid`, `rx_sym` and `overflow` are 0.
- R2: A symbol sent into an empty channel on clock edge E is delivered as a one-cycle `rx_valid` pulse, with `rx_sym` equal to its code, after edge E+DELAY+1. Symbol codes are REQ=1, ACK=2 and IDLE=3. `rx_sym` is 0 whenever `rx_valid` is low.
- R3: Sending the symbol that is newest on the channel leaves `link_state` unchanged. It causes no extra delivery and no overflow.
- R4: Sending a symbol that differs from the single one in flight forms a pair. The newer symbol is delivered DELAY+1 edges after its own send. The older symbol's delivery time is unchanged.
- R5: A pair always delivers its older symbol first. The newer symbol then remains as the single symbol.
- R6: Sending a third distinct symbol while a pair is in flight drops it. `overflow` pulses for one cycle and `link_state` does not change.
- R7: When a delivery and a send fall on the same edge, the delivery is applied first and the send acts on the state that remains.
- R8: A send with `tx_valid` low, or with code 0, has no effect on the channel.
- R9: `link_state` encoding: 0 = empty, 1 = REQ, 3 = ACK, 5 = IDLE. The ordered pairs, older symbol first, are 2 = REQ,ACK; 4 = ACK,IDLE; 6 = IDLE,REQ; 7 = ACK,REQ; 8 = REQ,IDLE; 9 = IDLE,ACK.
- R10: No symbol stays in flight longer than DELAY+1 edges. The age that decides delivery never exceeds DELAY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Send strobe |
| tx_sym | input | 2 | Symbol code to send (1 REQ, 2 ACK, 3 IDLE) |
| rx_valid | output | 1 | Registered one-cycle delivery pulse |
| rx_sym | output | 2 | Delivered symbol code, 0 when idle |
| overflow | output | 1 | One-cycle pulse when a third distinct symbol is dropped |
| link_state | output | 4 | Occupancy and order code, 0 to 9 |

## Verification
The assertions assume that the sender is free to strobe on any cycle with any code, code 0 included. They also assume that reset is held for at least one edge before traffic starts. Under those assumptions the delivery age, the pair-to-single step and the overflow condition must always hold. The stimulus sweeps every first, second and third symbol, including the null code, over every spacing from back-to-back up to beyond the delay on a small delay setting. These sweeps reach every pair state, same-edge delivery with send, and overflow. A pseudo-random stream with a high strobe rate then drives the inputs on idle cycles, so that `tx_sym` changes while `tx_valid` is low.

// File: rtl/sym_link_delay.sv
module sym_link_delay #(
  parameter int DELAY = 36
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_valid,
  input  logic [1:0] tx_sym,
  output logic       rx_valid,
  output logic [1:0] rx_sym,
  output logic       overflow,
  output logic [3:0] link_state
);
  localparam int AGE_MAX = DELAY + 1;
  localparam int AGE_W   = $clog2(AGE_MAX + 1);
  localparam logic [AGE_W-1:0] AGE_DUE = AGE_W'(DELAY);
  localparam logic [AGE_W-1:0] AGE_TOP = AGE_W'(AGE_MAX);
  localparam logic [1:0] S_REQ = 2'd1, S_ACK = 2'd2, S_IDLE = 2'd3;

  logic [1:0]       occ, sym_a, sym_b;
  logic [AGE_W-1:0] age_a, age_b;
  logic [1:0]       occ_n, sa_n, sb_n;
  logic [AGE_W-1:0] aa_n, ab_n;
  logic             ovf_n;

  wire [AGE_W-1:0] front_age = (occ == 2'd2) ? age_a : age_b;
  wire             due       = (occ != 2'd0) && (front_age == AGE_DUE);
  wire [1:0]       front_sym = (occ == 2'd2) ? sym_a : sym_b;
  wire             send      = tx_valid && (tx_sym != 2'd0);

  function automatic logic [AGE_W-1:0] age_inc(input logic [AGE_W-1:0] a);
    return (a == AGE_TOP) ? a : a + 1'b1;
  endfunction

  always_comb begin
    occ_n = occ;
    sa_n  = sym_a;
    sb_n  = sym_b;
    aa_n  = age_inc(age_a);
    ab_n  = age_inc(age_b);
    ovf_n = 1'b0;
    if (due) occ_n = occ - 2'd1;
    if (send) begin
      case (occ_n)
        2'd0: begin
          occ_n = 2'd1;
          sb_n  = tx_sym;
          aa_n  = '0;
          ab_n  = '0;
        end
        2'd1: begin
          if (tx_sym != sb_n) begin
            occ_n = 2'd2;
            sa_n  = sb_n;
            aa_n  = ab_n;
            sb_n  = tx_sym;
            ab_n  = '0;
          end
        end
        default: begin
          if (tx_sym != sb_n) ovf_n = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ      <= 2'd0;
      sym_a    <= 2'd0;
      sym_b    <= 2'd0;
      age_a    <= '0;
      age_b    <= '0;
      rx_valid <= 1'b0;
      rx_sym   <= 2'd0;
      overflow <= 1'b0;
    end else begin
      occ      <= occ_n;
      sym_a    <= sa_n;
      sym_b    <= sb_n;
      age_a    <= aa_n;
      age_b    <= ab_n;
      rx_valid <= due;
      rx_sym   <= due ? front_sym : 2'd0;
      overflow <= ovf_n;
    end
  end

  always_comb begin
    link_state = 4'd0;
    if (occ == 2'd1) begin
      case (sym_b)
        S_REQ:   link_state = 4'd1;
        S_ACK:   link_state = 4'd3;
        default: link_state = 4'd5;
      endcase
    end else if (occ == 2'd2) begin
      case ({sym_a, sym_b})
        {S_REQ, S_ACK}:  link_state = 4'd2;
        {S_ACK, S_IDLE}: link_state = 4'd4;
        {S_IDLE, S_REQ}: link_state = 4'd6;
        {S_ACK, S_REQ}:  link_state = 4'd7;
        {S_REQ, S_IDLE}: link_state = 4'd8;
        default:         link_state = 4'd9;
      endcase
    end
  end
endmodule

// File: rtl/sym_link_delay_chk.sv
module sym_link_delay_chk #(
  parameter int DELAY = 36,
  parameter int AGE_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic [1:0]       rx_sym,
  input logic             overflow,
  input logic [3:0]       link_state,
  input logic [1:0]       occ,
  input logic [AGE_W-1:0] front_age
);
  // R10
  a_r10_age_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (occ != 2'd0) |-> (int'(front_age) <= DELAY));
  // R2
  a_r2_rx_code: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_sym != 2'd0));
  a_r2_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> (rx_sym == 2'd0));
  // R9
  a_r9_state_range: assert property (@(posedge clk) disable iff (!rst_n)
    link_state <= 4'd9);
  // R6
  a_r6_overflow_from_pair: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> ($past(occ) == 2'd2));
  // R5
  a_r5_pair_leaves_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && $past(occ) == 2'd2) |-> (occ != 2'd0));
endmodule

bind sym_link_delay sym_link_delay_chk #(.DELAY(DELAY), .AGE_W(AGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sym(rx_sym),
  .overflow(overflow), .link_state(link_state), .occ(occ), .front_age(front_age)
);

// File: tb/sym_link_delay_bench.sv
`timescale 1ns/1ps
module sym_link_delay_bench;
  localparam int D = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_valid = 1'b0;
  logic [1:0] tx_sym = 2'd0;
  logic rx_valid, overflow;
  logic [1:0] rx_sym;
  logic [3:0] link_state;

  always #2.5 clk = ~clk;

  sym_link_delay #(.DELAY(D)) u_sym_link_delay (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_sym(tx_sym),
    .rx_valid(rx_valid), .rx_sym(rx_sym), .overflow(overflow), .link_state(link_state)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int edge_n = 0;
  int qs [2];
  int qd [2];
  int n = 0;
  int e_rx, e_sym, e_ovf, e_state;
  bit f_absorb, f_pair, f_same, f_ignored;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int state_code();
    if (n == 0) return 0;
    if (n == 1) return (qs[0] == 1) ? 1 : (qs[0] == 2) ? 3 : 5;
    case (qs[0] * 4 + qs[1])
      1*4+2: return 2;
      2*4+3: return 4;
      3*4+1: return 6;
      2*4+1: return 7;
      1*4+3: return 8;
      default: return 9;
    endcase
  endfunction

  task automatic predict(input bit v, input int s, input int e);
    int prev_state;
    prev_state = state_code();
    e_rx = 0; e_sym = 0; e_ovf = 0;
    f_absorb = 0; f_pair = 0; f_same = 0; f_ignored = 0;
    if (n > 0 && qd[0] == e) begin
      e_rx = 1; e_sym = qs[0];
      qs[0] = qs[1]; qd[0] = qd[1]; n--;
      f_same = v && (s != 0);
    end
    if (v && s != 0) begin
      if (n == 0) begin qs[0] = s; qd[0] = e + D + 1; n = 1; end
      else if (qs[n-1] == s) f_absorb = 1;
      else if (n == 1) begin qs[1] = s; qd[1] = e + D + 1; n = 2; f_pair = 1; end
      else e_ovf = 1;
    end else if (e_rx == 0) begin
      f_ignored = 1;
    end
    e_state = state_code();
    if (f_absorb && e_rx == 0 && e_state != prev_state) e_state = -1;
  endtask

  task automatic tick(input bit v, input int s);
    tx_valid = v;
    tx_sym = 2'(s);
    predict(v, s, edge_n + 1);
    @(posedge clk);
    edge_n++;
    @(negedge clk);
    chk("R2 rx_valid", int'(rx_valid), e_rx);
    chk("R5 rx_sym order", int'(rx_sym), e_sym);
    chk("R6 overflow", int'(overflow), e_ovf);
    chk("R9 link_state", int'(link_state), e_state);
    if (e_rx == 1) chk("R10 delivery on time", int'(rx_valid), 1);
    if (f_absorb) chk("R3 absorbed resend", int'(link_state), e_state);
    if (f_pair) chk("R4 pair formed", int'(link_state), e_state);
    if (f_same) chk("R7 deliver then send", int'(link_state), e_state);
    if (f_ignored) chk("R8 ignored input", int'(link_state), e_state);
  endtask

  task automatic idle_tick();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tick(1'b0, int'(lfsr[1:0]));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset link_state", int'(link_state), 0);
    chk("R1 reset rx_valid", int'(rx_valid), 0);
    chk("R1 reset rx_sym", int'(rx_sym), 0);
    chk("R1 reset overflow", int'(overflow), 0);

    for (int s1 = 1; s1 <= 3; s1++)
      for (int s2 = 0; s2 <= 3; s2++)
        for (int s3 = 0; s3 <= 3; s3++)
          for (int g = 0; g <= D + 1; g++) begin
            tick(1'b1, s1);
            repeat (g) idle_tick();
            tick(1'b1, s2);
            repeat (g) idle_tick();
            tick(1'b1, s3);
            repeat (D + 3) idle_tick();
          end

    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick(lfsr[3] | lfsr[5], int'(lfsr[1:0]));
    end
    repeat (D + 3) idle_tick();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule